// File: doc/BRIEF.md
# Software Watchdog Timer with Selectable Expiry Action

This block is a 32-bit software watchdog. Software writes a start value, selects what the block does when the count runs out, and then sets the enable bit. While enabled, a down-counter drops by one on every clock. Software keeps the system alive by writing the service register, which reloads the counter from the start value. If the counter reaches zero and is not serviced, the block expires and raises one of three outputs chosen by software: a hardware reset request, a nonmaskable interrupt, or a general-purpose interrupt.

Registers are reached through a simple single-cycle write port and a combinational read port. The address map is: 0 = start value, 1 = control, 2 = service when written and current counter when read, 3 = status. Status bit 0 is the sticky expired flag. Status bit 1 shows that the counter is halted after an expiry. The reset sequencer and the interrupt controller that receive the three outputs lie outside this block.

Top module: `wdt_top`

## Requirements
- R1: When a control write sets the enable bit (bit 0) while the timer is disabled, the counter loads the start value on that clock edge. While the timer is enabled and not halted, the counter then drops by one on every clock. While the timer is disabled, the counter holds its value.
- R2: Control register bit 0 is the enable. Bits 2:1 select the expiry action: 00 = reset request, 01 = nonmaskable interrupt, 10 = general interrupt, 11 = no action. Reading address 1 returns these three bits, with zeros above them.
- R3: Any write to address 2 reloads the counter from the start value at that clock edge and clears the halted state. If this write falls in the same cycle as an expiry, the write wins and no expiry occurs.
- R4: An expiry happens on a clock edge where the timer is enabled, not halted, and the counter is zero. The next cycle shows status bit 0 set. The bit stays set until software writes 1 to status bit 0. If a set and a clear arrive in the same cycle, the set wins.
- R5: With action 00, an expiry raises rst_req for exactly one clock cycle.
- R6: With action 01, an expiry raises nmi_req. The action is captured at the moment of expiry, and nmi_req stays high as long as the expired flag is set.
- R7: With action 10, an expiry raises irq_req. The action is captured at the moment of expiry, and irq_req stays high as long as the expired flag is set.
- R8: A write to address 0 while the timer is enabled is ignored. A write to address 0 while the timer is disabled changes only the start value and leaves the counter unchanged.
- R9: After an expiry, the counter stays at zero and status bit 1 is set. No further expiry occurs until a service write arrives or the enable bit goes from 0 to 1.
- R10: With action 11, an expiry sets the expired flag but raises none of rst_req, nmi_req or irq_req.
- R11: After reset, all registers, the counter, the flags and the three outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data for rd_addr (combinational) |
| rst_req | output | 1 | Single-cycle hardware reset request |
| nmi_req | output | 1 | Nonmaskable interrupt request (level) |
| irq_req | output | 1 | General interrupt request (level) |

## Verification
The hardest cases to reach from the ports are the ones where a register write lands on the exact edge where the counter sits at zero. These are a service write racing an expiry, and an expired-flag clear racing a new expiry. The bench reaches them with sweeps. Each sweep re-arms the timer with a small start value and then issues the competing write after a delay that steps across the expiry cycle, one cycle at a time. A behavioural model, compared on every clock, decides which side wins at each step.

// File: rtl/wdt_pkg.sv
// Shared types for the watchdog: expiry action codes and register addresses.
package wdt_pkg;
    typedef enum logic [1:0] {
        ACT_RESET = 2'b00,
        ACT_NMI   = 2'b01,
        ACT_IRQ   = 2'b10,
        ACT_NONE  = 2'b11
    } wdt_act_e;

    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_START  = 2'd0;
    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd1;
    localparam logic [ADDR_W-1:0] A_SERVE  = 2'd2;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd3;
endpackage

// File: rtl/wdt_regs.sv
// Register file of the watchdog: start value, control (enable and action),
// sticky expired flag, and the read mux.
// Assumes one write per cycle, with wr_en held high for one cycle per write.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              halted,
    input  logic              expire_evt,
    output logic [CNT_W-1:0]  start_val,
    output logic              en,
    output wdt_act_e          act_sel,
    output logic              svc_wr,
    output logic              en_rise,
    output logic              exp_flag,
    output logic [CNT_W-1:0]  rd_data
);
    localparam int CTRL_BITS = 3;

    logic ctrl_wr, start_wr, clr_wr;

    // Decode the write strobes from the address.
    always_comb begin
        start_wr = wr_en && (wr_addr == A_START);
        ctrl_wr  = wr_en && (wr_addr == A_CTRL);
        svc_wr   = wr_en && (wr_addr == A_SERVE);
        clr_wr   = wr_en && (wr_addr == A_STATUS) && wr_data[0];
        en_rise  = ctrl_wr && wr_data[0] && !en;
    end

    // Start value: writable only while the timer is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                start_val <= '0;
        else if (start_wr && !en)  start_val <= wr_data;
    end

    // Control register: enable bit and action select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en      <= 1'b0;
            act_sel <= ACT_RESET;
        end else if (ctrl_wr) begin
            en      <= wr_data[0];
            act_sel <= wdt_act_e'(wr_data[2:1]);
        end
    end

    // Sticky expired flag: a set outranks a write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          exp_flag <= 1'b0;
        else if (expire_evt) exp_flag <= 1'b1;
        else if (clr_wr)     exp_flag <= 1'b0;
    end

    // Read mux.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_START:  rd_data = start_val;
            A_CTRL:   rd_data[CTRL_BITS-1:0] = {act_sel, en};
            A_SERVE:  rd_data = cnt;
            default:  rd_data[1:0] = {halted, exp_flag};
        endcase
    end

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_evt |=> exp_flag);
    // R8
    start_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && en) |=> $stable(start_val));
endmodule

// File: rtl/wdt_counter.sv
// Down-counter of the watchdog. It loads the start value on enable or
// service, counts down while enabled, and reports expiry at zero. After
// expiry it halts until it is re-armed.
// Assumes svc_wr and en_rise are single-cycle strobes from the register file.
module wdt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             svc_wr,
    input  logic             en_rise,
    input  logic [CNT_W-1:0] start_val,
    output logic [CNT_W-1:0] cnt,
    output logic             halted,
    output logic             expire_evt
);
    // Expiry: running timer at zero, with no reload pending in this cycle.
    always_comb expire_evt = en && !halted && (cnt == '0) && !svc_wr && !en_rise;

    // Counter and halt state; a reload outranks counting and expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            halted <= 1'b0;
        end else if (svc_wr || en_rise) begin
            cnt    <= start_val;
            halted <= 1'b0;
        end else if (en && !halted) begin
            if (cnt == '0) halted <= 1'b1;
            else           cnt    <= cnt - 1'b1;
        end
    end

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !halted && cnt != '0 && !svc_wr && !en_rise) |=> (cnt == $past(cnt) - 1'b1));
    // R9
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !svc_wr && !en_rise) |=> (halted && cnt == '0 && !expire_evt));
    // R3
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_wr |=> (cnt == $past(start_val) && !halted));
endmodule

// File: rtl/wdt_action.sv
// Turns an expiry into the selected output. It captures the action at
// expiry, pulses the reset request for one cycle, and holds NMI or IRQ
// while the expired flag is set.
// Assumes expire_evt is a single-cycle strobe.
module wdt_action
    import wdt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     expire_evt,
    input  wdt_act_e act_sel,
    input  logic     exp_flag,
    output logic     rst_req,
    output logic     nmi_req,
    output logic     irq_req
);
    wdt_act_e act_lat;

    // Capture the action at expiry and form the single-cycle reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_lat <= ACT_NONE;
            rst_req <= 1'b0;
        end else begin
            rst_req <= expire_evt && (act_sel == ACT_RESET);
            if (expire_evt) act_lat <= act_sel;
        end
    end

    // Level interrupts follow the sticky flag.
    always_comb begin
        nmi_req = exp_flag && (act_lat == ACT_NMI);
        irq_req = exp_flag && (act_lat == ACT_IRQ);
    end

    // R5
    rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    // R6
    one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_req, nmi_req, irq_req}));
    // R10
    none_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_evt && act_sel == ACT_NONE) |=> !(rst_req || nmi_req || irq_req));
endmodule

// File: rtl/wdt_top.sv
// Watchdog top level: connects the register file, the counter and the
// expiry action logic.
// Assumes a single clock domain and a synchronous active-low reset.
module wdt_top
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              rst_req,
    output logic              nmi_req,
    output logic              irq_req
);
    logic [CNT_W-1:0] start_val, cnt;
    logic en, svc_wr, en_rise, exp_flag, halted, expire_evt;
    wdt_act_e act_sel;

    wdt_regs #(.CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .cnt(cnt), .halted(halted),
        .expire_evt(expire_evt), .start_val(start_val), .en(en),
        .act_sel(act_sel), .svc_wr(svc_wr), .en_rise(en_rise),
        .exp_flag(exp_flag), .rd_data(rd_data)
    );

    wdt_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .en(en), .svc_wr(svc_wr),
        .en_rise(en_rise), .start_val(start_val), .cnt(cnt),
        .halted(halted), .expire_evt(expire_evt)
    );

    wdt_action act_i (
        .clk(clk), .rst_n(rst_n), .expire_evt(expire_evt),
        .act_sel(act_sel), .exp_flag(exp_flag), .rst_req(rst_req),
        .nmi_req(nmi_req), .irq_req(irq_req)
    );
endmodule

// File: tb/wdt_top_tb_top.sv
module wdt_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic rst_req, nmi_req, irq_req;

    int n_checks = 0;
    int n_errors = 0;
    bit started = 0;
    bit hold_rd = 0;

    // behavioural reference state
    logic [31:0] m_start = 0, m_cnt = 0;
    logic m_en = 0, m_halt = 0, m_flag = 0, m_rst = 0;
    logic [1:0] m_act = 0, m_lat = 2'b11;

    always #10 clk = ~clk;

    wdt_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .rst_req(rst_req), .nmi_req(nmi_req), .irq_req(irq_req)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model, advanced on every clock edge
    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            m_start = 0; m_cnt = 0; m_en = 0; m_halt = 0; m_flag = 0;
            m_rst = 0; m_act = 0; m_lat = 2'b11;
        end else begin
            bit svc, rise, evt;
            svc  = wr_en && wr_addr == 2;
            rise = wr_en && wr_addr == 1 && wr_data[0] && !m_en;
            evt  = m_en && !m_halt && m_cnt == 0 && !svc && !rise;
            m_rst = evt && m_act == 2'b00;
            if (evt) m_lat = m_act;
            if (evt) m_flag = 1;
            else if (wr_en && wr_addr == 3 && wr_data[0]) m_flag = 0;
            if (svc || rise) begin m_cnt = m_start; m_halt = 0; end
            else if (m_en && !m_halt) begin
                if (m_cnt == 0) m_halt = 1; else m_cnt = m_cnt - 1;
            end
            if (wr_en && wr_addr == 0 && !m_en) m_start = wr_data;
            if (wr_en && wr_addr == 1) begin m_en = wr_data[0]; m_act = wr_data[2:1]; end
        end
    end

    function automatic logic [31:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return m_start;
            2'd1: return {29'd0, m_act, m_en};
            2'd2: return m_cnt;
            default: return {30'd0, m_halt, m_flag};
        endcase
    endfunction

    // compare on every clock, away from the edges
    always @(negedge clk) begin
        #2;
        if (started) begin
            check(rst_req == m_rst, "R5", rst_req, m_rst);
            check(nmi_req == (m_flag && m_lat == 2'b01), "R6", nmi_req, m_flag);
            check(irq_req == (m_flag && m_lat == 2'b10), "R7", irq_req, m_flag);
            case (rd_addr)
                2'd0: check(rd_data == m_read(rd_addr), "R8", rd_data, m_read(rd_addr));
                2'd1: check(rd_data == m_read(rd_addr), "R2", rd_data, m_read(rd_addr));
                2'd2: check(rd_data == m_read(rd_addr), "R1", rd_data, m_read(rd_addr));
                default: check(rd_data == m_read(rd_addr), "R4", rd_data, m_read(rd_addr));
            endcase
        end
        if (!hold_rd) rd_addr = rd_addr + 1;
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(input logic [1:0] a, input logic [31:0] exp, input string req);
        hold_rd = 1;
        @(negedge clk);
        rd_addr = a;
        #5;
        check(rd_data == exp, req, rd_data, exp);
        hold_rd = 0;
    endtask

    initial begin
        #(20 * 150000);
        n_errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int pulses;
        idle(3);
        // R11: reset state
        check({rst_req, nmi_req, irq_req} == 0, "R11", {rst_req, nmi_req, irq_req}, 0);
        rst_n = 1;
        peek(2'd3, 0, "R11");
        peek(2'd2, 0, "R11");

        // NMI expiry (R6), then halt (R9), then clear (R4)
        wr(0, 5);
        wr(1, 32'b011);
        idle(10);
        check(nmi_req == 1, "R6", nmi_req, 1);
        peek(2'd3, 3, "R9");
        idle(5);
        peek(2'd2, 0, "R9");
        wr(3, 1);
        #3 check(nmi_req == 0, "R4", nmi_req, 0);
        // R3: regular servicing prevents expiry
        wr(2, 0);
        for (int i = 0; i < 6; i++) begin idle(2); wr(2, 0); end
        peek(2'd3, 0, "R3");
        // R8: start write while enabled is ignored
        wr(0, 100);
        peek(2'd0, 5, "R8");

        // R5: reset action, pulse width
        wr(1, 0);
        wr(0, 3);
        peek(2'd2, 0, "R8");
        wr(1, 32'b001);
        pulses = 0;
        for (int i = 0; i < 12; i++) begin @(negedge clk); #3; if (rst_req) pulses++; end
        check(pulses == 1, "R5", pulses, 1);
        wr(3, 1);

        // R7: general interrupt
        wr(1, 0);
        wr(1, 32'b101);
        idle(8);
        check(irq_req == 1 && nmi_req == 0, "R7", irq_req, 1);
        wr(3, 1);

        // R10: no action
        wr(1, 0);
        wr(1, 32'b111);
        idle(8);
        check({rst_req, nmi_req, irq_req} == 0, "R10", {rst_req, nmi_req, irq_req}, 0);
        peek(2'd3, 3, "R10");
        wr(3, 1);

        // R3 race: service swept across the expiry cycle
        for (int d = 0; d < 8; d++) begin
            wr(1, 0); wr(3, 1);
            wr(1, 32'b011);
            idle(d);
            wr(2, 0);
            idle(2);
        end
        // R4 race: clear swept across a fresh expiry
        for (int d = 0; d < 8; d++) begin
            wr(1, 0);
            wr(1, 32'b011);
            idle(d);
            wr(3, 1);
            idle(6);
        end
        // R1: start value of zero expires at once
        wr(1, 0); wr(3, 1); wr(0, 0);
        wr(1, 32'b101);
        idle(3);
        check(irq_req == 1, "R1", irq_req, 1);
        idle(4);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule